// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block is the per-core reservation unit behind load-linked / store-conditional synchronisation. It sits between one core's request port and a shared word-addressed memory, and it watches the write traffic that other cores put on the shared bus. A load-linked request returns the addressed word and arms a reservation, which is a single flag plus the reserved word address. A later store-conditional lets its write reach memory only while that flag is still armed, and it reports to the core whether the write happened.

The reservation is cancelled without notice by a snooped write from any other core to the reserved word, by an interrupt or exception, and by a context switch. The bus is never held between the two halves of the pair. Other cores keep full access throughout, and the monitor only observes their writes. Writes carrying this core's own ID do not cancel the reservation. Memory is modelled as a simple array with one port for this core and one for the snooped bus.

Top module: `llsc_monitor`

## Requirements
- R1: Request opcodes are 0 = plain load, 1 = plain store, 2 = load-linked, 3 = store-conditional. A load-linked returns the addressed word one cycle later, arms the reservation flag and saves the word address.
- R2: A store-conditional writes memory only if the reservation flag is armed when it executes. Otherwise memory is left unchanged.
- R3: Every accepted request produces `rsp_valid_o` exactly one cycle later. `rsp_sc_ok_o` carries the flag value seen by a store-conditional (1 = written, 0 = suppressed) and is 0 for every other opcode. `rsp_rdata_o` carries the word for loads and load-linked requests and is 0 otherwise.
- R4: Every store-conditional disarms the flag, whether it succeeds or fails, so a second store-conditional with no new load-linked fails.
- R5: A snooped write whose ID differs from `MY_ID` and whose address equals the reserved address disarms the flag. A foreign write to any other address leaves the flag armed.
- R6: Asserting `irq_i` or `ctx_sw_i` for one cycle disarms the flag.
- R7: A snooped write tagged with `MY_ID` never disarms the flag.
- R8: A new load-linked replaces any earlier reservation. The saved address is held until the next load-linked, even after the flag is disarmed.
- R9: If a disarming event and a store-conditional fall in the same cycle, the event wins: the store-conditional fails and writes nothing.
- R10: If a disarming event falls in the same cycle as a load-linked, the address is still saved but the flag stays disarmed. A foreign write counts as such an event when it hits the new address.
- R11: Reset disarms the flag and clears memory to zero, so a store-conditional with no earlier load-linked fails.
- R12: Plain stores always write. Snooped writes of any ID update memory. When the core and the bus write the same word in the same cycle, the bus value is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Core request present this cycle |
| req_op_i | input | 2 | Request opcode (see R1) |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_wdata_i | input | DATA_W | Store data |
| irq_i | input | 1 | Interrupt or exception event |
| ctx_sw_i | input | 1 | Context-switch event |
| snp_valid_i | input | 1 | Write observed on the shared bus |
| snp_id_i | input | ID_W | ID of the core issuing the bus write |
| snp_addr_i | input | ADDR_W | Word address of the bus write |
| snp_wdata_i | input | DATA_W | Data of the bus write |
| rsp_valid_o | output | 1 | Response for the request of the previous cycle |
| rsp_rdata_o | output | DATA_W | Read word for loads and load-linked requests |
| rsp_sc_ok_o | output | 1 | Store-conditional status |

## Verification
The interesting collision is a store-conditional landing in the same cycle as a disarming event: a foreign write to the reserved word, an interrupt or a context switch. The same kind of collision can also hit a load-linked. Directed cases place each event in exactly the cycle of the store-conditional or load-linked. They judge the outcome by the returned status and by reading the word back with a plain load. A seeded random phase confines addresses to four words and mixes opcodes, events and foreign and own-ID bus writes densely. Each response is compared with a bench-side reference model of the flag, the address and memory.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } op_e;

endpackage

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_addr];

    // The bus write is applied last so it wins a same-word collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (core_we) begin
                mem_q[core_addr] <= core_wdata;
            end
            if (bus_we) begin
                mem_q[bus_addr] <= bus_wdata;
            end
        end
    end

    AST_BUS_WINS_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && core_we && bus_addr == core_addr)
        |=> mem_q[$past(bus_addr)] == $past(bus_wdata)) // R12
        else $error("bus write lost a same-word collision");

endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
    parameter int              ADDR_W = 8,
    parameter int              ID_W   = 2,
    parameter logic [ID_W-1:0] MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_link,
    input  logic              is_cond,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              irq,
    input  logic              ctx_sw,
    input  logic              snp_valid,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              sc_ok,
    output logic              armed
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } resv_t;

    resv_t resv_d, resv_q;
    logic  foreign, hit_cur, hit_new, evt;

    always_comb begin
        foreign = snp_valid && (snp_id != MY_ID);
        hit_cur = foreign && (snp_addr == resv_q.addr);
        hit_new = foreign && (snp_addr == req_addr);
        evt     = irq || ctx_sw;
        resv_d  = resv_q;
        sc_ok   = 1'b0;
        if (is_link) begin
            resv_d.addr  = req_addr;
            resv_d.valid = !(evt || hit_new);
        end else if (is_cond) begin
            sc_ok        = resv_q.valid && !(evt || hit_cur);
            resv_d.valid = 1'b0;
        end else if (evt || hit_cur) begin
            resv_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_q <= '0;
        end else begin
            resv_q <= resv_d;
        end
    end

    assign armed = resv_q.valid;

    AST_LINK_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_link && !irq && !ctx_sw && !hit_new)
        |=> resv_q.valid && resv_q.addr == $past(req_addr)) // R1
        else $error("load-linked did not arm");
    AST_OK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> resv_q.valid && is_cond) // R2
        else $error("success without armed flag");
    AST_COND_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        is_cond |=> !resv_q.valid) // R4
        else $error("store-conditional left flag armed");
    AST_FOREIGN_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cur && !is_link) |=> !resv_q.valid) // R5
        else $error("foreign write did not disarm");
    AST_EVENT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || ctx_sw) |=> !resv_q.valid) // R6
        else $error("event did not disarm");
    AST_OWN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (resv_q.valid && snp_valid && snp_id == MY_ID && !is_cond && !irq && !ctx_sw)
        |=> resv_q.valid) // R7
        else $error("own write disarmed");
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_link |=> $stable(resv_q.addr)) // R8
        else $error("saved address changed without load-linked");
    AST_NO_SELF_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_link && !resv_q.valid) |=> !resv_q.valid) // R11
        else $error("flag armed without load-linked");

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter int              DATA_W = 32,
    parameter int              ID_W   = 2,
    parameter logic [ID_W-1:0] MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              irq_i,
    input  logic              ctx_sw_i,
    input  logic              snp_valid_i,
    input  logic [ID_W-1:0]   snp_id_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [DATA_W-1:0] snp_wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              rsp_sc_ok_o
);
    typedef struct packed {
        logic              valid;
        logic              sc_ok;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    op_e               op;
    logic              is_link, is_cond, is_read, sc_ok, armed, core_we;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        op      = op_e'(req_op_i);
        is_link = req_valid_i && (op == OP_LINK);
        is_cond = req_valid_i && (op == OP_COND);
        is_read = req_valid_i && (op == OP_LOAD || op == OP_LINK);
        core_we = req_valid_i && ((op == OP_STORE) || (op == OP_COND && sc_ok));
        rsp_d.valid = req_valid_i;
        rsp_d.sc_ok = is_cond && sc_ok;
        rsp_d.rdata = is_read ? rd_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    llsc_resv #(.ADDR_W(ADDR_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_link   (is_link),
        .is_cond   (is_cond),
        .req_addr  (req_addr_i),
        .irq       (irq_i),
        .ctx_sw    (ctx_sw_i),
        .snp_valid (snp_valid_i),
        .snp_id    (snp_id_i),
        .snp_addr  (snp_addr_i),
        .sc_ok     (sc_ok),
        .armed     (armed)
    );

    llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (req_addr_i),
        .rd_data    (rd_data),
        .core_we    (core_we),
        .core_addr  (req_addr_i),
        .core_wdata (req_wdata_i),
        .bus_we     (snp_valid_i),
        .bus_addr   (snp_addr_i),
        .bus_wdata  (snp_wdata_i)
    );

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_rdata_o = rsp_q.rdata;
    assign rsp_sc_ok_o = rsp_q.sc_ok;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o) // R3
        else $error("missing response");
    AST_OK_IMPLIES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_ok_o |-> rsp_valid_o) // R3
        else $error("status without response");
    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cond && (!armed || irq_i || ctx_sw_i)) |-> !core_we) // R9
        else $error("failed store-conditional wrote memory");

endmodule

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int IW = 2;
    localparam logic [IW-1:0] ME = 2'd1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [1:0]    req_op_i = '0;
    logic [AW-1:0] req_addr_i = '0;
    logic [DW-1:0] req_wdata_i = '0;
    logic          irq_i = 1'b0, ctx_sw_i = 1'b0;
    logic          snp_valid_i = 1'b0;
    logic [IW-1:0] snp_id_i = '0;
    logic [AW-1:0] snp_addr_i = '0;
    logic [DW-1:0] snp_wdata_i = '0;
    logic          rsp_valid_o, rsp_sc_ok_o;
    logic [DW-1:0] rsp_rdata_o;

    int n_chk = 0, n_fail = 0;

    // Reference model
    logic [DW-1:0] m_mem [1 << AW];
    logic          m_flag = 1'b0;
    logic [AW-1:0] m_addr = '0;

    always #10 clk = ~clk;  // 50 MHz

    llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .ID_W(IW), .MY_ID(ME)) i_llsc_monitor (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_op_i(req_op_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .irq_i(irq_i), .ctx_sw_i(ctx_sw_i),
        .snp_valid_i(snp_valid_i), .snp_id_i(snp_id_i), .snp_addr_i(snp_addr_i),
        .snp_wdata_i(snp_wdata_i), .rsp_valid_o(rsp_valid_o),
        .rsp_rdata_o(rsp_rdata_o), .rsp_sc_ok_o(rsp_sc_ok_o)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic foreign_hit(input logic v, input logic [IW-1:0] id,
                                         input logic [AW-1:0] a, input logic [AW-1:0] ref_a);
        return v && (id != ME) && (a == ref_a);
    endfunction

    // One cycle: drive at negedge, model, clock, compare at next negedge.
    task automatic cyc(input string tag, input logic v, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [DW-1:0] wd,
                       input logic irq, input logic ctx,
                       input logic sv, input logic [IW-1:0] sid,
                       input logic [AW-1:0] sa, input logic [DW-1:0] sd);
        logic          e_ok;
        logic [DW-1:0] e_rd;
        logic          evt;
        req_valid_i = v; req_op_i = op; req_addr_i = a; req_wdata_i = wd;
        irq_i = irq; ctx_sw_i = ctx;
        snp_valid_i = sv; snp_id_i = sid; snp_addr_i = sa; snp_wdata_i = sd;
        evt  = irq || ctx;
        e_ok = 1'b0;
        e_rd = (v && (op == 2'd0 || op == 2'd2)) ? m_mem[a] : '0;
        if (v && op == 2'd2) begin
            m_addr = a;
            m_flag = !(evt || foreign_hit(sv, sid, sa, a));
        end else if (v && op == 2'd3) begin
            e_ok = m_flag && !(evt || foreign_hit(sv, sid, sa, m_addr));
            if (e_ok) m_mem[a] = wd;
            m_flag = 1'b0;
        end else begin
            if (evt || foreign_hit(sv, sid, sa, m_addr)) m_flag = 1'b0;
        end
        if (v && op == 2'd1) m_mem[a] = wd;
        if (sv) m_mem[sa] = sd;
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0; irq_i = 1'b0; ctx_sw_i = 1'b0; snp_valid_i = 1'b0;
        check({tag, " valid"}, {31'd0, rsp_valid_o}, {31'd0, v});
        check({tag, " rdata"}, rsp_rdata_o, e_rd);
        check({tag, " sc_ok"}, {31'd0, rsp_sc_ok_o}, {31'd0, e_ok});
    endtask

    task automatic req(input string tag, input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd);
        cyc(tag, 1'b1, op, a, wd, 1'b0, 1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic bus(input string tag, input logic [IW-1:0] id, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        cyc(tag, 1'b0, 2'd0, '0, '0, 1'b0, 1'b0, 1'b1, id, a, d);
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check("R11 reset rsp_valid", {31'd0, rsp_valid_o}, 32'd0);
        check("R11 reset sc_ok", {31'd0, rsp_sc_ok_o}, 32'd0);
        req("R11 cond without link", 2'd3, 8'h10, 32'hdead);
        req("R11 load after failed cond", 2'd0, 8'h10, '0);
        // R1 R2 R3 basic pair
        req("R12 store", 2'd1, 8'h10, 32'h1);
        req("R1 link", 2'd2, 8'h10, '0);
        req("R2 cond ok", 2'd3, 8'h10, 32'h0);
        req("R2 readback", 2'd0, 8'h10, '0);
        req("R4 second cond", 2'd3, 8'h10, 32'h7);
        // R5 foreign write hit / miss
        req("R5 link", 2'd2, 8'h20, '0);
        bus("R5 foreign miss", 2'd2, 8'h21, 32'h55);
        bus("R5 foreign hit", 2'd0, 8'h20, 32'h66);
        req("R5 cond after hit", 2'd3, 8'h20, 32'h77);
        req("R5 readback", 2'd0, 8'h20, '0);
        req("R5 link2", 2'd2, 8'h20, '0);
        bus("R5 foreign other addr", 2'd3, 8'h22, 32'h1);
        req("R5 cond kept", 2'd3, 8'h20, 32'h88);
        // R7 own-ID write
        req("R7 link", 2'd2, 8'h30, '0);
        bus("R7 own write", ME, 8'h30, 32'h99);
        req("R7 cond ok", 2'd3, 8'h30, 32'haa);
        // R6 irq and ctx
        req("R6 link", 2'd2, 8'h31, '0);
        cyc("R6 irq", 1'b0, 2'd0, '0, '0, 1'b1, 1'b0, 1'b0, '0, '0, '0);
        req("R6 cond after irq", 2'd3, 8'h31, 32'h1);
        req("R6 link2", 2'd2, 8'h31, '0);
        cyc("R6 ctx", 1'b0, 2'd0, '0, '0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        req("R6 cond after ctx", 2'd3, 8'h31, 32'h2);
        // R9 same-cycle collisions with cond
        req("R9 link", 2'd2, 8'h40, '0);
        cyc("R9 cond+irq", 1'b1, 2'd3, 8'h40, 32'h3, 1'b1, 1'b0, 1'b0, '0, '0, '0);
        req("R9 readback", 2'd0, 8'h40, '0);
        req("R9 link2", 2'd2, 8'h40, '0);
        cyc("R9 cond+foreign", 1'b1, 2'd3, 8'h40, 32'h4, 1'b0, 1'b0, 1'b1, 2'd2, 8'h40, 32'h5);
        req("R9 readback2", 2'd0, 8'h40, '0);
        // R10 event with link
        cyc("R10 link+foreign", 1'b1, 2'd2, 8'h41, '0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h41, 32'h6);
        req("R10 cond fails", 2'd3, 8'h41, 32'h7);
        cyc("R10 link+ctx", 1'b1, 2'd2, 8'h42, '0, 1'b0, 1'b1, 1'b0, '0, '0, '0);
        req("R10 cond fails2", 2'd3, 8'h42, 32'h8);
        // R8 replacement
        req("R8 link a", 2'd2, 8'h50, '0);
        req("R8 link b", 2'd2, 8'h51, '0);
        bus("R8 foreign old addr", 2'd0, 8'h50, 32'h9);
        req("R8 cond on new", 2'd3, 8'h51, 32'hb);
        // R12 collision
        cyc("R12 store vs bus", 1'b1, 2'd1, 8'h60, 32'hc, 1'b0, 1'b0, 1'b1, 2'd2, 8'h60, 32'hd);
        req("R12 readback", 2'd0, 8'h60, '0);
        // Random mix, R3 response checks against model
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] op = 2'($urandom % 4);
            cyc("R3 random", ($urandom % 4) != 0, op, 8'($urandom % 4), $urandom,
                ($urandom % 16) == 0, ($urandom % 16) == 0,
                ($urandom % 3) == 0, 2'($urandom % 4), 8'($urandom % 4), $urandom);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule